// File: doc/BRIEF.md
# Accumulator Row Transfer Path with Interleaved Mode

This block sits between a 4 KB accumulator array and a 64-byte memory data bus. The accumulator holds 64 rows of 64 bytes. Each row is viewed as sixteen 32-bit elements, with element j at bits [32j+31:32j]. A command moves data between the bus and the array. A plain transfer moves one row, or two consecutive rows when the pair flag is set. An interleaved transfer builds one 64-byte bus row from matching halves of two neighbouring accumulator rows, woven together element by element. An interleaved load does the reverse: it scatters one bus row back into those two halves.

The command carries a 2-bit kind, a 6-bit row index and a pair flag. Kind bit 0 selects store (1) or load (0). Kind bit 1 selects interleaved (1) or plain (0). Load data is presented on `wr_data` and is written in the same cycle it is accepted. Store data appears on `rd_data` one cycle after the beat that requested it. `done` pulses once per beat, one cycle after that beat. Address generation toward memory and fault handling belong to other blocks.

Top module: `zacc_row_xfer`

## Requirements
- R1: After reset, `done` is 0 and `rd_data` is all zeros.
- R2: A plain single-row load (kind 00, pair 0) writes `wr_data` into row `cmd_row` on the command edge. `done` is high for exactly the one cycle that follows.
- R3: A plain single-row store (kind 01, pair 0) drives the contents of row `cmd_row` on `rd_data` in the cycle after the command, with `done` high in that same cycle.
- R4: A plain transfer with pair set takes two beats on consecutive rows. The first beat uses the command cycle. For a load, the second beat's data is taken from `wr_data` in the cycle after the command. Each beat produces its own one-cycle `done`, so `done` is high for two cycles in a row.
- R5: A pair transfer whose start row is odd is aligned down, so it covers rows 2*(r/2) and 2*(r/2)+1.
- R6: A command presented during the second beat of a pair transfer is ignored. It neither writes the array nor produces a `done`.
- R7: An interleaved store (kind 11) with index n reads rows a = 2*(n/2) and b = a+1. Bit n[0] selects the half: 0 means elements 0..7, 1 means elements 8..15. Output element 2k is element (8*n[0]+k) of row a, and output element 2k+1 is the same element of row b, for k = 0..7. Index 63 uses rows 62 and 63.
- R8: An interleaved load (kind 10) with index n writes `wr_data` element 2k into row a and element 2k+1 into row b, at element 8*n[0]+k. The other half of both rows is left unchanged.
- R9: Interleaved transfers are always a single beat, whatever the pair flag says.
- R10: `rd_data` changes only in cycles where `done` is high, and holds its last store value through loads and idle cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_kind | input | 2 | Bit 0: store(1)/load(0); bit 1: interleaved(1)/plain(0) |
| cmd_row | input | 6 | Row index (plain) or interleaved row index |
| cmd_pair | input | 1 | Two-row transfer (plain mode only) |
| wr_data | input | 512 | Load data, one row per beat |
| rd_data | output | 512 | Store data, valid with `done` |
| done | output | 1 | One pulse per completed beat |

## Verification
A wrong row select, an interleave that misplaces elements, or a half-select error corrupts array state that stays hidden until a later store reads it. The bench therefore follows every load with stores that cover both the written rows and the halves that should be untouched, so such damage shows up on `rd_data` one cycle after that store. A bad pending-beat flag shows at once as a missing, extra or misplaced `done` pulse. A stray command accepted during a second beat shows when the row it would have overwritten is read back.

// File: rtl/zacc_row_xfer.sv
module zacc_row_xfer #(
  parameter int ROWS      = 64,
  parameter int ROW_BYTES = 64,
  parameter int ELEM_BITS = 32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cmd_valid,
  input  logic [1:0]             cmd_kind,
  input  logic [$clog2(ROWS)-1:0] cmd_row,
  input  logic                   cmd_pair,
  input  logic [ROW_BYTES*8-1:0] wr_data,
  output logic [ROW_BYTES*8-1:0] rd_data,
  output logic                   done
);
  localparam int ROW_W = ROW_BYTES * 8;
  localparam int IDX_W = $clog2(ROWS);
  localparam int ELEMS = ROW_W / ELEM_BITS;
  localparam int HALF  = ELEMS / 2;

  localparam logic [1:0] K_LD  = 2'b00;
  localparam logic [1:0] K_ST  = 2'b01;
  localparam logic [1:0] K_ILD = 2'b10;
  localparam logic [1:0] K_IST = 2'b11;

  logic [ROW_W-1:0] acc [ROWS];

  logic             busy, busy_load;
  logic [IDX_W-1:0] busy_row;

  logic             go;
  logic [IDX_W-1:0] plain_row, ev_row, od_row;
  logic             hsel;
  logic [ROW_W-1:0] row_a, row_b, woven, new_a, new_b;

  assign go        = cmd_valid & ~busy;
  assign ev_row    = {cmd_row[IDX_W-1:1], 1'b0};
  assign od_row    = {cmd_row[IDX_W-1:1], 1'b1};
  assign hsel      = cmd_row[0];
  assign plain_row = cmd_pair ? ev_row : cmd_row;
  assign row_a     = acc[ev_row];
  assign row_b     = acc[od_row];

  always_comb begin
    woven = '0;
    new_a = row_a;
    new_b = row_b;
    for (int k = 0; k < HALF; k++) begin
      woven[(2*k)*ELEM_BITS +: ELEM_BITS] =
        row_a[((hsel ? HALF : 0) + k)*ELEM_BITS +: ELEM_BITS];
      woven[(2*k+1)*ELEM_BITS +: ELEM_BITS] =
        row_b[((hsel ? HALF : 0) + k)*ELEM_BITS +: ELEM_BITS];
      new_a[((hsel ? HALF : 0) + k)*ELEM_BITS +: ELEM_BITS] =
        wr_data[(2*k)*ELEM_BITS +: ELEM_BITS];
      new_b[((hsel ? HALF : 0) + k)*ELEM_BITS +: ELEM_BITS] =
        wr_data[(2*k+1)*ELEM_BITS +: ELEM_BITS];
    end
  end

  always_ff @(posedge clk) begin
    if (busy && busy_load) begin
      acc[busy_row] <= wr_data;
    end else if (go) begin
      case (cmd_kind)
        K_LD:  acc[plain_row] <= wr_data;
        K_ILD: begin
          acc[ev_row] <= new_a;
          acc[od_row] <= new_b;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done      <= 1'b0;
      busy      <= 1'b0;
      busy_load <= 1'b0;
      busy_row  <= '0;
      rd_data   <= '0;
    end else begin
      done <= busy | go;
      busy <= go & ~cmd_kind[1] & cmd_pair;
      if (go) begin
        busy_load <= ~cmd_kind[0];
        busy_row  <= od_row;
      end
      if (busy) begin
        if (!busy_load) rd_data <= acc[busy_row];
      end else if (go) begin
        if (cmd_kind == K_ST)       rd_data <= acc[plain_row];
        else if (cmd_kind == K_IST) rd_data <= woven;
      end
    end
  end
endmodule

// File: rtl/zacc_row_xfer_chk.sv
module zacc_row_xfer_chk #(
  parameter int W = 512
) (
  input logic         clk,
  input logic         rst_n,
  input logic         cmd_valid,
  input logic [1:0]   cmd_kind,
  input logic         cmd_pair,
  input logic         busy,
  input logic         done,
  input logic [W-1:0] rd_data
);
  AST_CMD_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !busy) |=> done);                                   // R2
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_valid && !busy) |=> !done);                                 // R6
  AST_PAIR_SECOND: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !busy && cmd_pair && !cmd_kind[1]) |=> (busy && done)); // R4
  AST_BUSY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (!busy && done));                                        // R4
  AST_ILV_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !busy && cmd_kind[1]) |=> !busy);                   // R9
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rd_data) |-> done);                                      // R10
endmodule

bind zacc_row_xfer zacc_row_xfer_chk #(.W(ROW_BYTES*8)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_kind(cmd_kind),
  .cmd_pair(cmd_pair), .busy(busy), .done(done), .rd_data(rd_data)
);

// File: tb/tb_zacc_row_xfer.sv
module tb_zacc_row_xfer;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cmd_valid = 1'b0;
  logic [1:0]   cmd_kind = 2'b00;
  logic [5:0]   cmd_row = '0;
  logic         cmd_pair = 1'b0;
  logic [511:0] wr_data = '0;
  logic [511:0] rd_data;
  logic         done;

  always #2.5 clk = ~clk;

  zacc_row_xfer dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_kind(cmd_kind),
    .cmd_row(cmd_row), .cmd_pair(cmd_pair), .wr_data(wr_data),
    .rd_data(rd_data), .done(done)
  );

  typedef struct {
    logic [511:0] val;
    string        req;
  } exp_t;

  exp_t         exp_q[$];
  logic [511:0] model [64];
  logic [511:0] last_rd = '0;
  int checks = 0;
  int fails  = 0;

  function automatic logic [511:0] pat(int seed);
    logic [511:0] v;
    for (int j = 0; j < 16; j++) v[32*j +: 32] = (seed * 32'h9E3779B9) ^ (j * 32'h01010101) ^ 32'h5A000000;
    return v;
  endfunction

  function automatic logic [511:0] weave(int n);
    logic [511:0] v;
    int a = (n / 2) * 2;
    int h = (n % 2) * 8;
    for (int k = 0; k < 8; k++) begin
      v[32*(2*k) +: 32]   = model[a][32*(h+k) +: 32];
      v[32*(2*k+1) +: 32] = model[a+1][32*(h+k) +: 32];
    end
    return v;
  endfunction

  task automatic check(string req, logic [511:0] act, logic [511:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic push(string req, logic [511:0] v);
    exp_t e;
    e.val = v;
    e.req = req;
    exp_q.push_back(e);
    last_rd = v;
  endtask

  // Issue one command; pair plain transfers take a second beat with d1.
  // stray: present an extra load to row 5 during the second beat.
  task automatic issue(logic [1:0] kind, int row, bit pair, logic [511:0] d0,
                       logic [511:0] d1, string req, bit stray = 0);
    int r;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_kind = kind; cmd_row = row[5:0]; cmd_pair = pair;
    wr_data = d0;
    r = (pair && !kind[1]) ? (row / 2) * 2 : row;
    case (kind)
      2'b00: begin model[r] = d0; push(req, last_rd); end
      2'b01: push(req, model[r]);
      2'b10: begin
        for (int k = 0; k < 8; k++) begin
          model[(row/2)*2][32*((row%2)*8+k) +: 32]   = d0[32*(2*k) +: 32];
          model[(row/2)*2+1][32*((row%2)*8+k) +: 32] = d0[32*(2*k+1) +: 32];
        end
        push(req, last_rd);
      end
      default: push(req, weave(row));
    endcase
    if (pair && !kind[1]) begin
      if (kind == 2'b00) begin model[r+1] = d1; push(req, last_rd); end
      else push(req, model[r+1]);
      @(negedge clk);
      wr_data = d1;
      if (stray) begin
        cmd_valid = 1'b1; cmd_kind = 2'b00; cmd_row = 6'd5; cmd_pair = 1'b0;
      end else cmd_valid = 1'b0;
    end
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  // Monitor: compare every done beat against the queue head.
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (exp_q.size() == 0) begin
        checks++; fails++;
        $display("FAIL R6: actual unexpected done expected no done");
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check(e.req, rd_data, e.val);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    check("R1", {511'b0, done}, 512'b0);
    check("R1", rd_data, 512'b0);
    rst_n = 1'b1;
    // Fill all rows so every later read is defined (R2)
    for (int i = 0; i < 64; i++) issue(2'b00, i, 0, pat(i + 1), '0, "R2");
    for (int i = 0; i < 8; i++) issue(2'b01, i * 9 % 64, 0, '0, '0, "R3");
    // Pair load/store from even start (R4)
    issue(2'b00, 10, 1, pat(100), pat(101), "R4");
    issue(2'b01, 10, 0, '0, '0, "R4");
    issue(2'b01, 11, 0, '0, '0, "R4");
    issue(2'b01, 10, 1, '0, '0, "R4");
    // Odd start aligned down (R5)
    issue(2'b00, 13, 1, pat(200), pat(201), "R5");
    issue(2'b01, 12, 0, '0, '0, "R5");
    issue(2'b01, 13, 1, '0, '0, "R5");
    // Stray command during second beat ignored (R6)
    issue(2'b00, 20, 1, pat(300), pat(301), "R6", 1);
    issue(2'b01, 5, 0, '0, '0, "R6");
    issue(2'b01, 20, 1, '0, '0, "R6");
    // Interleaved store mapping, including wrap index 63 (R7)
    issue(2'b11, 0, 0, '0, '0, "R7");
    issue(2'b11, 1, 0, '0, '0, "R7");
    issue(2'b11, 2, 0, '0, '0, "R7");
    issue(2'b11, 3, 0, '0, '0, "R7");
    issue(2'b11, 63, 0, '0, '0, "R7");
    // Interleaved load touches only the chosen halves (R8)
    issue(2'b10, 5, 0, pat(400), '0, "R8");
    issue(2'b01, 4, 0, '0, '0, "R8");
    issue(2'b01, 5, 0, '0, '0, "R8");
    issue(2'b10, 30, 0, pat(401), '0, "R8");
    issue(2'b01, 30, 1, '0, '0, "R8");
    issue(2'b11, 31, 0, '0, '0, "R8");
    // Pair flag ignored in interleaved mode (R9)
    issue(2'b10, 2, 1, pat(500), '0, "R9");
    issue(2'b11, 2, 1, '0, '0, "R9");
    issue(2'b01, 2, 1, '0, '0, "R9");
    // rd_data holds across loads and idle (R10)
    issue(2'b00, 40, 0, pat(600), '0, "R10");
    repeat (4) @(negedge clk);
    check("R10", rd_data, last_rd);
    repeat (4) @(negedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      fails++;
      $display("FAIL R4: actual %0d pending beats expected 0", exp_q.size());
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule